// File: doc/BRIEF.md
# Column-Parallel Single-Slope Conversion Back End

This block is the digital side of a bank of single-slope converters that work side by side, one channel per column. One Gray-coded counter runs while the analog ramp sweeps and is driven onto a shared bus to every channel. Each channel receives its comparator result as a plain digital input. That input passes through a synchronizer. On the first rising edge seen in a ramp, the channel stores the bus code in its capture register (A). If a channel's comparator never rises during the ramp, its capture register is filled with the full-scale code once the ramp ends.

Once the ramp has finished, a copy strobe moves every capture register into its holding register (B). The next row can then convert into A while software-independent readout logic drains B. A column select picks one holding register, and the block converts its Gray value to plain binary before it leaves the block. A start pulse chooses one of two resolutions: the full code width, or one bit less.

A sequencer with three states controls the ramp. `ST_IDLE` waits for a start pulse. `ST_RAMP` advances the counter once per clock and opens the capture window. `ST_CLOSE` lasts one cycle and fills every channel that never captured. The transitions are: IDLE→RAMP on a start pulse, RAMP→CLOSE when the counter reaches full scale, and CLOSE→IDLE unconditionally.

Top module: `ssadc_backend`

## Requirements
- R1: After reset, `busy_o` is 0, `gray_bus_o` is 0, and every column reads 0 on `rd_code_o`.
- R2: A start pulse sampled in IDLE clears the counter to 0 on that edge and raises `busy_o` from that edge on.
- R3: During a ramp the bus shows the Gray code of k (g = k xor (k>>1)) after the k-th clock edge following the start edge. Successive bus values therefore differ in exactly one bit.
- R4: `res10_i` is sampled with the start pulse. A value of 1 selects full scale 1023 (10-bit); a value of 0 selects full scale 511 (9-bit). The counter stops at full scale, and `busy_o` stays high for exactly full scale + 2 cycles.
- R5: A comparator input that first goes high just before clock edge j after the start edge produces the code j+1, provided j+1 ≤ full scale. This accounts for two synchronizer stages plus edge detection.
- R6: Only the first rising comparator edge in a conversion is stored. Later falls and rises leave the captured code unchanged.
- R7: A column whose comparator input never rises in time holds the full-scale code after the ramp.
- R8: A copy pulse while idle moves every column's captured code into its holding register. The holding register is read as binary through `rd_sel_i` (0 = first column).
- R9: A copy pulse while `busy_o` is high has no effect on the holding registers.
- R10: The holding registers keep their values while the next conversion runs.
- R11: A select value of `NUM_CH` or above reads 0.
- R12: A start pulse during a ramp is ignored, and the counter keeps advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion start pulse |
| res10_i | input | 1 | 1 = 10-bit ramp, 0 = 9-bit ramp (sampled with start) |
| cmp_i | input | NUM_CH | Comparator outputs, one per column, asynchronous |
| copy_i | input | 1 | Capture-to-holding copy strobe |
| rd_sel_i | input | SEL_W | Column select for readout |
| busy_o | output | 1 | Ramp or close phase in progress |
| gray_bus_o | output | CODE_W | Shared Gray-coded timestamp bus |
| rd_code_o | output | CODE_W | Binary code of the selected holding register |

## Verification
On every cycle, the assertions check the following: each counter step flips exactly one bus bit, the counter clears on start and holds at full scale, RAMP moves to CLOSE at full scale, and a start pulse during a ramp leaves the state unchanged. Inside each column they also check that a stored code is frozen after capture, that the fill code is written at close, and that the holding register changes only on a gated copy. Only the bench scenarios can show the end-to-end latency arithmetic from a raw comparator rise to a binary readout value. The same applies to the choice between the two resolutions, and to whether data survives across an overlapped second conversion.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RAMP  = 2'd1,
        ST_CLOSE = 2'd2
    } ramp_state_e;

    typedef struct packed {
        logic clr;      // clear counter and capture flags
        logic inc;      // advance the counter
        logic cap_en;   // capture window open
        logic close;    // fill uncaptured columns
        logic copy_ok;  // copy strobe allowed
    } seq_ctrl_t;

endpackage

// File: rtl/ssadc_gray_cnt.sv
module ssadc_gray_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    input  logic [W-1:0] fs_i,
    output logic [W-1:0] gray_o,
    output logic         at_full_o
);

    logic [W-1:0] bin_q;
    logic [W-1:0] gray_q;
    logic [W-1:0] bin_nxt;

    assign bin_nxt   = bin_q + 1'b1;
    assign at_full_o = (bin_q == fs_i);
    assign gray_o    = gray_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (clr_i) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (inc_i && !at_full_o) begin
            bin_q  <= bin_nxt;
            gray_q <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

    // R3: each advance flips exactly one bus bit
    a_r3_single_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && !at_full_o) |=> ($countones(gray_q ^ $past(gray_q)) == 1));

    // R2: start clears the counter
    a_r2_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (gray_q == '0));

    // R4: counter holds at full scale
    a_r4_hold_at_full: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && at_full_o && !clr_i) |=> $stable(gray_q));

endmodule

// File: rtl/ssadc_seq.sv
module ssadc_seq
    import ssadc_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         res_hi_i,
    input  logic         at_full_i,
    output seq_ctrl_t    ctrl_o,
    output logic [W-1:0] fs_o,
    output logic         busy_o
);

    localparam logic [W-1:0] FS_HI = {W{1'b1}};
    localparam logic [W-1:0] FS_LO = {1'b0, {(W-1){1'b1}}};

    ramp_state_e state_q, state_d;
    logic        res_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            res_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                res_q <= res_hi_i;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)   state_d = ST_RAMP;
            ST_RAMP:  if (at_full_i) state_d = ST_CLOSE;
            ST_CLOSE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ctrl_o = '0;
        busy_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ctrl_o.clr     = start_i;
                ctrl_o.copy_ok = 1'b1;
            end
            ST_RAMP: begin
                ctrl_o.inc    = 1'b1;
                ctrl_o.cap_en = 1'b1;
                busy_o        = 1'b1;
            end
            ST_CLOSE: begin
                ctrl_o.close = 1'b1;
                busy_o       = 1'b1;
            end
            default: ;
        endcase
    end

    assign fs_o = res_q ? FS_HI : FS_LO;

    // R4: ramp ends at full scale
    a_r4_ramp_to_close: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && at_full_i) |=> (state_q == ST_CLOSE));

    // R12: start during ramp is ignored
    a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && start_i && !at_full_i) |=> (state_q == ST_RAMP));

    // R4: close lasts one cycle
    a_r4_close_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLOSE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/ssadc_col.sv
module ssadc_col #(
    parameter int W    = 10,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_i,
    input  logic         clr_i,
    input  logic         cap_en_i,
    input  logic         close_i,
    input  logic         copy_i,
    input  logic [W-1:0] bus_i,
    input  logic [W-1:0] fs_gray_i,
    output logic [W-1:0] reg_b_o
);

    logic [SYNC-1:0] sync_q;
    logic            prev_q;
    logic            rise;
    logic            cap_q;
    logic [W-1:0]    reg_a;
    logic [W-1:0]    reg_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], cmp_i};
            prev_q <= sync_q[SYNC-1];
        end
    end

    assign rise = sync_q[SYNC-1] & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
            reg_a <= '0;
        end else if (clr_i) begin
            cap_q <= 1'b0;
        end else if (cap_en_i && rise && !cap_q) begin
            reg_a <= bus_i;
            cap_q <= 1'b1;
        end else if (close_i && !cap_q) begin
            reg_a <= fs_gray_i;
            cap_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_b <= '0;
        end else if (copy_i) begin
            reg_b <= reg_a;
        end
    end

    assign reg_b_o = reg_b;

    // R5: first edge stores the bus code
    a_r5_capture_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en_i && rise && !cap_q && !clr_i) |=> (reg_a == $past(bus_i)));

    // R6: a stored code is frozen until the next start
    a_r6_first_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q && !clr_i) |=> $stable(reg_a));

    // R7: uncaptured column takes full scale at close
    a_r7_full_scale_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (close_i && !cap_q && !clr_i) |=> (reg_a == $past(fs_gray_i)));

    // R9 / R10: holding register only changes on a gated copy
    a_r9_copy_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_i |=> $stable(reg_b));

endmodule

// File: rtl/ssadc_backend.sv
module ssadc_backend
    import ssadc_pkg::*;
#(
    parameter int NUM_CH      = 20,
    parameter int CODE_W      = 10,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              res10_i,
    input  logic [NUM_CH-1:0] cmp_i,
    input  logic              copy_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic              busy_o,
    output logic [CODE_W-1:0] gray_bus_o,
    output logic [CODE_W-1:0] rd_code_o
);

    seq_ctrl_t         ctrl;
    logic [CODE_W-1:0] fs_bin;
    logic [CODE_W-1:0] fs_gray;
    logic [CODE_W-1:0] bus;
    logic              at_full;
    logic              copy_gated;
    logic [CODE_W-1:0] regb [NUM_CH];

    ssadc_seq #(.W(CODE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .res_hi_i  (res10_i),
        .at_full_i (at_full),
        .ctrl_o    (ctrl),
        .fs_o      (fs_bin),
        .busy_o    (busy_o)
    );

    ssadc_gray_cnt #(.W(CODE_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (ctrl.clr),
        .inc_i     (ctrl.inc),
        .fs_i      (fs_bin),
        .gray_o    (bus),
        .at_full_o (at_full)
    );

    assign fs_gray    = fs_bin ^ (fs_bin >> 1);
    assign copy_gated = copy_i & ctrl.copy_ok;
    assign gray_bus_o = bus;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_col
        ssadc_col #(.W(CODE_W), .SYNC(SYNC_STAGES)) u_col (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmp_i     (cmp_i[gi]),
            .clr_i     (ctrl.clr),
            .cap_en_i  (ctrl.cap_en),
            .close_i   (ctrl.close),
            .copy_i    (copy_gated),
            .bus_i     (bus),
            .fs_gray_i (fs_gray),
            .reg_b_o   (regb[gi])
        );
    end

    // readout: select and Gray-to-binary decode
    always_comb begin
        logic [CODE_W-1:0] g;
        g         = '0;
        rd_code_o = '0;
        if (int'(rd_sel_i) < NUM_CH) begin
            g = regb[rd_sel_i];
            rd_code_o[CODE_W-1] = g[CODE_W-1];
            for (int i = CODE_W - 2; i >= 0; i--) begin
                rd_code_o[i] = rd_code_o[i+1] ^ g[i];
            end
        end
    end

    // R11: out-of-range select reads zero
    a_r11_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_sel_i) >= NUM_CH) |-> (rd_code_o == '0));

    // R2: start in idle makes the block busy
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && gray_bus_o == '0));

endmodule

// File: tb/test_ssadc_backend.sv
`timescale 1ns/1ps
module test_ssadc_backend;

    localparam int N  = 20;
    localparam int W  = 10;
    localparam int SW = $clog2(N);
    localparam int NV = 5;

    // stimulus table: resolution, first rise cycle, rise spacing per column, glitch on even columns
    localparam int V_RES  [NV] = '{0, 1, 0, 1, 0};
    localparam int V_BASE [NV] = '{5, 1, 490, 1100, 3};
    localparam int V_STEP [NV] = '{23, 53, 2, 0, 0};
    localparam int V_GL   [NV] = '{1, 0, 1, 0, 1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          res10 = 1'b0;
    logic [N-1:0]  cmp = '0;
    logic          copy = 1'b0;
    logic [SW-1:0] rd_sel = '0;
    logic          busy;
    logic [W-1:0]  gbus;
    logic [W-1:0]  rd_code;

    int checks = 0;
    int fails  = 0;
    int prev_exp [N];
    int cur_exp  [N];

    always #2.5 clk = ~clk;

    ssadc_backend i_ssadc_backend (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .res10_i    (res10),
        .cmp_i      (cmp),
        .copy_i     (copy),
        .rd_sel_i   (rd_sel),
        .busy_o     (busy),
        .gray_bus_o (gbus),
        .rd_code_o  (rd_code)
    );

    function automatic int to_gray(int v);
        return v ^ (v >> 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_col(input int c, input int exp, input string req);
        rd_sel = SW'(c);
        #0.05;
        chk(req, int'(rd_code), exp);
    endtask

    task automatic conversion(input int res, input int base, input int step, input int gl);
        int fs;
        fs = res ? 1023 : 511;
        for (int c = 0; c < N; c++) begin
            int j;
            j = base + step * c;
            cur_exp[c] = (j + 1 <= fs) ? j + 1 : fs;
        end
        @(negedge clk);
        cmp = '0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        res10 = res[0];
        @(posedge clk);
        for (int k = 1; k <= fs + 2; k++) begin
            @(negedge clk);
            start = (k == 30);
            copy  = (k == 10);
            if (k == 1) chk("R2 busy after start", int'(busy), 1);
            chk("R3 bus gray step", int'(gbus), to_gray((k - 1 < fs) ? k - 1 : fs));
            if (k == 31) chk("R12 start in ramp ignored", int'(gbus), to_gray(30));
            if (k == fs + 2) chk("R4 busy at last cycle", int'(busy), 1);
            if (k == 20) begin
                for (int c = 0; c < N; c++) read_col(c, prev_exp[c], "R10 holding kept in ramp");
            end
            for (int c = 0; c < N; c++) begin
                int j;
                j = base + step * c;
                cmp[c] = (k >= j) && !(gl != 0 && (c % 2) == 0 && k >= j + 3 && k < j + 6);
            end
        end
        @(negedge clk);
        start = 1'b0;
        copy  = 1'b0;
        chk("R4 idle after full+2", int'(busy), 0);
        for (int c = 0; c < N; c++) read_col(c, prev_exp[c], "R9 copy in ramp ignored");
        copy = 1'b1;
        @(negedge clk);
        copy = 1'b0;
        for (int c = 0; c < N; c++) begin
            read_col(c, cur_exp[c], (cur_exp[c] == fs) ? "R7 full scale" : "R5 R6 R8 capture code");
            prev_exp[c] = cur_exp[c];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < N; c++) prev_exp[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 bus", int'(gbus), 0);
        for (int c = 0; c < N; c++) read_col(c, 0, "R1 holding zero");
        // main table
        for (int v = 0; v < NV; v++) begin
            conversion(V_RES[v], V_BASE[v], V_STEP[v], V_GL[v]);
        end
        // R11: out-of-range select
        rd_sel = SW'(N);
        #0.05;
        chk("R11 select N", int'(rd_code), 0);
        rd_sel = '1;
        #0.05;
        chk("R11 select max", int'(rd_code), 0);
        // R9: copy while idle after another ramp but strobe held only during ramp
        conversion(1, 1000, 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule